// File: doc/BRIEF.md
# Shader Control-Flow Sequencer

This block walks a shader's control-flow program. It reads one 64-bit control-flow word at a time from instruction memory, starting at word pair 0 and moving forward in order. Each word is one of three things: an ALU-clause word, a position-export word, or a no-operation word. The block classifies the word and acts on it before it fetches the next one.

For an ALU-clause word, the sequencer extracts the clause address, the instruction count and the two constant-bank parameters. It then holds a start request to an ALU engine until that engine reports the clause complete. For a position export, it issues a one-cycle pulse that carries the source register and the four lane selects. A normal-layout word with its end-of-program flag set finishes the run. Any opcode the block does not handle stops the run and raises an error flag. A start pulse launches a new run.

Top module: `cfs_sequencer`

## Requirements
- R1: While reset is held, and until the first start, `imem_rd`, `clause_start`, `exp_valid`, `done` and `err` are 0.
- R2: After a start, word pairs are read at addresses 0, 1, 2 … in order. Each read is a one-cycle `imem_rd` strobe, and `imem_rdata` is valid in the cycle after it. At most one word is in flight.
- R3: The 7-bit opcode is `w1[29:23]`, where w1 is `imem_rdata[63:32]` and w0 is `imem_rdata[31:0]`. A value of 0x40 or more selects the ALU-clause layout, whose 4-bit clause kind is `w1[29:26]`. Kinds 8 to 13 are accepted.
- R4: For an accepted ALU-clause word, the outputs are set as follows:
  - `clause_base` = `w0[21:0]`×2
  - `clause_len` = (`w1[24:18]`+1)×2
  - `kbank0_idx` = `w0[25:22]`
  - `kbank1_idx` = `w0[29:26]`
  - `kbank0_base` = `w1[9:2]`×16
  - `kbank1_base` = `w1[17:10]`×16
- R5: `clause_start` stays high, with all clause outputs unchanged, until `clause_done` is sampled high. No word is fetched during that time.
- R6: Opcodes 0x27 and 0x28 are export words. The export type is `w0[14:13]`, the array base is `w0[12:0]` and the burst count is `w1[20:17]`. An export with type 1, array base equal to POS_BASE (60 by default) and burst count 0 produces a one-cycle `exp_valid`. That pulse carries `exp_src` = `w0[21:15]` and `exp_swz` = `w1[11:0]`, with lane 0 selected by bits 2:0 and lane 3 by bits 11:9.
- R7: Opcode 0x00 is a no-operation. It produces no clause and no export.
- R8: In the normal layout only, `w1[21]` is end-of-program. After such a word has been acted on, `done` rises and no further word is fetched. In the ALU layout, that bit is part of the count and does not end the run.
- R9: The following are unsupported:
  - any other normal-layout opcode;
  - ALU kinds 14 and 15;
  - an export that is not a position export with burst count 0.

  An unsupported word sets `err`. `err` stays set, no further word is fetched, no clause or export is issued, and `done` stays 0.
- R10: A start is accepted when the block is idle, finished or halted. It clears `done` and `err` and restarts from word pair 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run at word pair 0 |
| imem_rd | output | 1 | Read strobe to instruction memory |
| imem_addr | output | PC_W | Word-pair address |
| imem_rdata | input | 64 | Word pair, valid one cycle after the strobe |
| clause_start | output | 1 | ALU clause request, held until done |
| clause_done | input | 1 | ALU clause finished |
| clause_base | output | 23 | Clause start word offset |
| clause_len | output | 9 | Clause length in words |
| kbank0_idx | output | 4 | Constant bank 0 index |
| kbank1_idx | output | 4 | Constant bank 1 index |
| kbank0_base | output | 12 | Constant bank 0 base |
| kbank1_base | output | 12 | Constant bank 1 base |
| exp_valid | output | 1 | Position export pulse |
| exp_src | output | 7 | Export source register |
| exp_swz | output | 12 | Four 3-bit lane selects |
| done | output | 1 | Program reached its end |
| err | output | 1 | Sticky unsupported-word flag |

## Verification
A wrong program counter shows up at the ports on the very next `imem_rd` strobe, because the bench checks every read address against the expected sequence. A misclassified word produces an event out of order within two cycles of its fetch. That event can be a clause, an export, `done` or `err`, and the scoreboard rejects it when it arrives, or reports a missing event when the run ends. A broken handshake or halt state would show as a fetch during a clause or after the end of the run. The bench watches for that for several cycles after each run stops.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  localparam int CL_BASE_W = 23;
  localparam int CL_LEN_W  = 9;
  localparam int KB_IDX_W  = 4;
  localparam int KB_BASE_W = 12;
  localparam int SRC_W     = 7;
  localparam int SWZ_W     = 12;

  localparam logic [6:0] OPC_NOP      = 7'h00;
  localparam logic [6:0] OPC_EXP      = 7'h27;
  localparam logic [6:0] OPC_EXP_LAST = 7'h28;
  localparam logic [6:0] OPC_ALU_MIN  = 7'h40;

  typedef enum logic [1:0] {K_NOP, K_ALU, K_EXP, K_BAD} cf_kind_e;

  typedef struct packed {
    logic [CL_BASE_W-1:0] base;
    logic [CL_LEN_W-1:0]  len;
    logic [KB_IDX_W-1:0]  kb0;
    logic [KB_IDX_W-1:0]  kb1;
    logic [KB_BASE_W-1:0] kbase0;
    logic [KB_BASE_W-1:0] kbase1;
  } clause_t;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic [SWZ_W-1:0] swz;
  } export_t;
endpackage

// File: rtl/cfs_decode.sv
module cfs_decode
  import cfs_pkg::*;
#(
  parameter int POS_BASE = 60,
  parameter int KIND_LO  = 8,
  parameter int KIND_HI  = 13
) (
  input  logic [63:0] word,
  output cf_kind_e    kind,
  output logic        eop,
  output clause_t     cl,
  output export_t     ex
);
  logic [31:0] w0, w1;
  logic [6:0]  opc;
  logic [3:0]  alu_kind;
  logic        is_pos;
  logic        unused_bits;

  assign w0 = word[31:0];
  assign w1 = word[63:32];
  assign opc = w1[29:23];
  assign alu_kind = w1[29:26];
  assign unused_bits = ^{w0[31:30], w1[31:30]};

  // Field extraction for both layouts (only one is acted on)
  always_comb begin
    cl.base   = {w0[21:0], 1'b0};
    cl.len    = {({1'b0, w1[24:18]} + 8'd1), 1'b0};
    cl.kb0    = w0[25:22];
    cl.kb1    = w0[29:26];
    cl.kbase0 = {w1[9:2], 4'b0000};
    cl.kbase1 = {w1[17:10], 4'b0000};
    ex.src    = w0[21:15];
    ex.swz    = w1[11:0];
  end

  assign is_pos = (w0[14:13] == 2'd1) && (w0[12:0] == 13'(POS_BASE)) &&
                  (w1[20:17] == 4'd0);

  always_comb begin
    kind = K_BAD;
    eop  = 1'b0;
    if (opc >= OPC_ALU_MIN) begin
      if (alu_kind >= 4'(KIND_LO) && alu_kind <= 4'(KIND_HI)) kind = K_ALU;
    end else begin
      eop = w1[21];
      if (opc == OPC_NOP) kind = K_NOP;
      else if ((opc == OPC_EXP || opc == OPC_EXP_LAST) && is_pos) kind = K_EXP;
    end
  end
endmodule

// File: rtl/cfs_fsm.sv
module cfs_fsm
  import cfs_pkg::*;
#(
  parameter int PC_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  cf_kind_e        kind,
  input  logic            eop,
  input  logic            clause_done,
  output logic            imem_rd,
  output logic [PC_W-1:0] pc,
  output logic            cap_clause,
  output logic            cap_export,
  output logic            in_clause,
  output logic            done,
  output logic            err
);
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_DECODE, S_CLAUSE, S_DONE, S_HALT} st_e;
  st_e state, state_n;
  logic [PC_W-1:0] pc_n;
  logic            pc_en;
  logic            in_decode;

  assign in_decode = (state == S_DECODE);

  always_comb begin
    state_n = state;
    pc_n    = pc;
    pc_en   = 1'b0;
    unique case (state)
      S_IDLE, S_DONE, S_HALT: begin
        if (start) begin
          state_n = S_FETCH;
          pc_n    = '0;
          pc_en   = 1'b1;
        end
      end
      S_FETCH: state_n = S_DECODE;
      S_DECODE: begin
        pc_n  = pc + PC_W'(1);
        pc_en = (kind != K_BAD);
        unique case (kind)
          K_ALU:        state_n = S_CLAUSE;
          K_NOP, K_EXP: state_n = eop ? S_DONE : S_FETCH;
          default:      state_n = S_HALT;
        endcase
      end
      S_CLAUSE: if (clause_done) state_n = S_FETCH;
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      pc    <= '0;
    end else begin
      state <= state_n;
      if (pc_en) pc <= pc_n;
    end
  end

  assign imem_rd    = (state == S_FETCH);
  assign in_clause  = (state == S_CLAUSE);
  assign done       = (state == S_DONE);
  assign err        = (state == S_HALT);
  assign cap_clause = in_decode && (kind == K_ALU);
  assign cap_export = in_decode && (kind == K_EXP);
endmodule

// File: rtl/cfs_outreg.sv
module cfs_outreg
  import cfs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cap_clause,
  input  logic    cap_export,
  input  clause_t cl_in,
  input  export_t ex_in,
  output clause_t cl_q,
  output export_t ex_q,
  output logic    exp_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cl_q      <= '0;
      ex_q      <= '0;
      exp_valid <= 1'b0;
    end else begin
      exp_valid <= cap_export;
      if (cap_clause) cl_q <= cl_in;
      if (cap_export) ex_q <= ex_in;
    end
  end
endmodule

// File: rtl/cfs_sequencer.sv
module cfs_sequencer
  import cfs_pkg::*;
#(
  parameter int PC_W     = 10,
  parameter int POS_BASE = 60,
  parameter int KIND_LO  = 8,
  parameter int KIND_HI  = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            imem_rd,
  output logic [PC_W-1:0] imem_addr,
  input  logic [63:0]     imem_rdata,
  output logic            clause_start,
  input  logic            clause_done,
  output logic [22:0]     clause_base,
  output logic [8:0]      clause_len,
  output logic [3:0]      kbank0_idx,
  output logic [3:0]      kbank1_idx,
  output logic [11:0]     kbank0_base,
  output logic [11:0]     kbank1_base,
  output logic            exp_valid,
  output logic [6:0]      exp_src,
  output logic [11:0]     exp_swz,
  output logic            done,
  output logic            err
);
  logic [1:0] rst_sync;
  logic       rst_n_i;
  cf_kind_e   kind;
  logic       eop, cap_clause, cap_export;
  clause_t    cl_d, cl_q;
  export_t    ex_d, ex_q;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  cfs_decode #(.POS_BASE(POS_BASE), .KIND_LO(KIND_LO), .KIND_HI(KIND_HI)) u_dec (
    .word(imem_rdata), .kind(kind), .eop(eop), .cl(cl_d), .ex(ex_d)
  );

  cfs_fsm #(.PC_W(PC_W)) u_fsm (
    .clk(clk), .rst_n(rst_n_i), .start(start), .kind(kind), .eop(eop),
    .clause_done(clause_done), .imem_rd(imem_rd), .pc(imem_addr),
    .cap_clause(cap_clause), .cap_export(cap_export), .in_clause(clause_start),
    .done(done), .err(err)
  );

  cfs_outreg u_out (
    .clk(clk), .rst_n(rst_n_i), .cap_clause(cap_clause), .cap_export(cap_export),
    .cl_in(cl_d), .ex_in(ex_d), .cl_q(cl_q), .ex_q(ex_q), .exp_valid(exp_valid)
  );

  assign clause_base = cl_q.base;
  assign clause_len  = cl_q.len;
  assign kbank0_idx  = cl_q.kb0;
  assign kbank1_idx  = cl_q.kb1;
  assign kbank0_base = cl_q.kbase0;
  assign kbank1_base = cl_q.kbase1;
  assign exp_src     = ex_q.src;
  assign exp_swz     = ex_q.swz;
endmodule

// File: rtl/cfs_sequencer_chk.sv
module cfs_sequencer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        imem_rd,
  input logic        clause_start,
  input logic        clause_done,
  input logic [22:0] clause_base,
  input logic [8:0]  clause_len,
  input logic        exp_valid,
  input logic        done,
  input logic        err
);
  // R2: a read is followed by a decode cycle, never a back-to-back read
  a_r2_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
    imem_rd |=> !imem_rd);

  // R5: request held until acknowledged
  a_r5_hold_start: assert property (@(posedge clk) disable iff (!rst_n)
    clause_start && !clause_done |=> clause_start);

  // R5: clause fields steady while requested
  a_r5_stable_fields: assert property (@(posedge clk) disable iff (!rst_n)
    clause_start && $past(clause_start) |-> $stable(clause_base) && $stable(clause_len));

  // R5: no fetch during a clause
  a_r5_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    clause_start |-> !imem_rd);

  // R6: export is a single-cycle pulse
  a_r6_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    exp_valid |=> !exp_valid);

  // R8: finished run is quiet
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !imem_rd && !clause_start);

  // R9: error is sticky until a new start
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err && !start |=> err);

  // R9: error and finish are exclusive
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
endmodule

bind cfs_sequencer cfs_sequencer_chk u_chk (.*);

// File: tb/sim_cfs_sequencer.sv
`timescale 1ns/1ps
module sim_cfs_sequencer;
  localparam int PC_W = 10;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic clause_done = 1'b0;
  logic [63:0] imem_rdata = '0;
  logic imem_rd, clause_start, exp_valid, done, err;
  logic [PC_W-1:0] imem_addr;
  logic [22:0] clause_base;
  logic [8:0]  clause_len;
  logic [3:0]  kbank0_idx, kbank1_idx;
  logic [11:0] kbank0_base, kbank1_base;
  logic [6:0]  exp_src;
  logic [11:0] exp_swz;

  always #10 clk = ~clk;

  cfs_sequencer #(.PC_W(PC_W)) u0 (.*);

  int checks = 0, failures = 0;
  logic [63:0] mem [16];
  logic [65:0] expq [$];
  int exp_pc = 0;
  int cycles = 0;
  logic cl_busy = 1'b0;
  int cl_cnt = 0;
  logic prev_done = 1'b0, prev_err = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // word builders
  function automatic logic [63:0] w_alu(input logic [21:0] a, input logic [3:0] k0, k1,
                                        input logic [7:0] b0, b1, input logic [6:0] cm1,
                                        input logic [3:0] kind);
    logic [31:0] w0, w1;
    w0 = {2'b00, k1, k0, a};
    w1 = '0;
    w1[29:26] = kind; w1[24:18] = cm1; w1[17:10] = b1; w1[9:2] = b0;
    return {w1, w0};
  endfunction

  function automatic logic [63:0] w_norm(input logic [6:0] opc, input logic eop,
                                         input logic [1:0] typ, input logic [12:0] base,
                                         input logic [6:0] src, input logic [11:0] swz,
                                         input logic [3:0] burst);
    logic [31:0] w0, w1;
    w0 = '0; w1 = '0;
    w0[12:0] = base; w0[14:13] = typ; w0[21:15] = src;
    w1[29:23] = opc; w1[21] = eop; w1[20:17] = burst; w1[11:0] = swz;
    return {w1, w0};
  endfunction

  function automatic logic [65:0] e_clause(input logic [21:0] a, input logic [3:0] k0, k1,
                                           input logic [7:0] b0, b1, input logic [6:0] cm1);
    logic [8:0] len;
    len = 9'(cm1) + 9'd1;
    return {2'd0, {a, 1'b0}, 9'(len * 2), k0, k1, {b0, 4'h0}, {b1, 4'h0}};
  endfunction

  function automatic logic [65:0] e_exp(input logic [6:0] src, input logic [11:0] swz);
    return {2'd1, 45'd0, src, swz};
  endfunction

  // memory model: one-cycle read latency
  always @(posedge clk) if (imem_rd) imem_rdata <= mem[imem_addr[3:0]];

  // monitor / scoreboard, sampled away from the active edge
  always @(negedge clk) begin
    logic [65:0] e;
    cycles++;
    if (imem_rd) begin
      chk(int'(imem_addr) == exp_pc, "R2 fetch order", 64'(imem_addr), 64'(exp_pc));
      exp_pc++;
    end
    clause_done = 1'b0;
    if (clause_start) begin
      if (!cl_busy) begin
        cl_busy = 1'b1; cl_cnt = 0;
        if (expq.size() == 0) chk(0, "R4 unexpected clause", 64'(clause_base), 0);
        else begin
          e = expq.pop_front();
          chk(e[65:64] == 2'd0 && e[63:0] == {clause_base, clause_len, kbank0_idx,
              kbank1_idx, kbank0_base, kbank1_base}, "R4 clause fields",
              {clause_base, clause_len, kbank0_idx, kbank1_idx, kbank0_base, kbank1_base}, e[63:0]);
        end
      end else begin
        cl_cnt++;
        if (cl_cnt == 3) clause_done = 1'b1;
      end
    end else cl_busy = 1'b0;
    if (exp_valid) begin
      if (expq.size() == 0) chk(0, "R6 unexpected export", 64'({exp_src, exp_swz}), 0);
      else begin
        e = expq.pop_front();
        chk(e[65:64] == 2'd1 && e[63:0] == 64'({exp_src, exp_swz}), "R6 export fields",
            64'({exp_src, exp_swz}), e[63:0]);
      end
    end
    if (done && !prev_done) begin
      if (expq.size() == 0) chk(0, "R8 unexpected done", 1, 0);
      else begin e = expq.pop_front(); chk(e[65:64] == 2'd2, "R8 done order", 64'(e[65:64]), 2); end
    end
    if (err && !prev_err) begin
      if (expq.size() == 0) chk(0, "R9 unexpected err", 1, 0);
      else begin e = expq.pop_front(); chk(e[65:64] == 2'd3, "R9 err order", 64'(e[65:64]), 3); end
    end
    prev_done = done; prev_err = err;
  end

  // watchdog
  always @(negedge clk) if (cycles > 100000) begin
    checks++; failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic clear_mem();
    for (int i = 0; i < 16; i++) mem[i] = w_norm(7'h3F, 1'b0, 2'd0, 13'd0, 7'd0, 12'd0, 4'd0);
  endtask

  task automatic run(input string tag);
    int t, pc_end;
    @(negedge clk);
    exp_pc = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!done && !err, "R10 start clears flags", {done, err}, 0);
    t = 0;
    while (!done && !err && t < 500) begin @(negedge clk); t++; end
    pc_end = exp_pc;
    repeat (6) @(negedge clk);
    chk(exp_pc == pc_end, "R8 R9 no fetch after stop", 64'(exp_pc), 64'(pc_end));
    chk(expq.size() == 0, {tag, " all expected events seen"}, 64'(expq.size()), 0);
    expq.delete();
  endtask

  localparam logic [6:0] NOP = 7'h00, EXP = 7'h27, EXPL = 7'h28;

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk({imem_rd, clause_start, exp_valid, done, err} == 0, "R1 in reset",
        {imem_rd, clause_start, exp_valid, done, err}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk({imem_rd, clause_start, exp_valid, done, err} == 0, "R1 idle after reset",
        {imem_rd, clause_start, exp_valid, done, err}, 0);

    // P1: clause, export, nop+end (R3 R4 R5 R6 R7 R8)
    clear_mem();
    mem[0] = w_alu(22'd5, 4'd2, 4'd3, 8'd1, 8'd2, 7'd3, 4'd8);
    mem[1] = w_norm(EXP, 1'b0, 2'd1, 13'd60, 7'd9, 12'o3210, 4'd0);
    mem[2] = w_norm(NOP, 1'b0, 2'd0, 13'd0, 7'd0, 12'd0, 4'd0);
    mem[3] = w_norm(NOP, 1'b1, 2'd0, 13'd0, 7'd0, 12'd0, 4'd0);
    expq.push_back(e_clause(22'd5, 4'd2, 4'd3, 8'd1, 8'd2, 7'd3));
    expq.push_back(e_exp(7'd9, 12'o3210));
    expq.push_back({2'd2, 64'd0});
    run("P1");
    chk(done && !err, "R8 done held", {done, err}, 2'b10);

    // P2: extreme fields, kinds 13 and 9, ALU bit21 not end, export-last with end (R3 R4 R8)
    clear_mem();
    mem[0] = w_alu(22'h3FFFFF, 4'hF, 4'h0, 8'hFF, 8'h00, 7'h7F, 4'd13);
    mem[1] = w_alu(22'h0, 4'h0, 4'hF, 8'h00, 8'hFF, 7'h00, 4'd9);
    mem[2] = w_norm(EXPL, 1'b1, 2'd1, 13'd60, 7'h7F, 12'hFFF, 4'd0);
    expq.push_back(e_clause(22'h3FFFFF, 4'hF, 4'h0, 8'hFF, 8'h00, 7'h7F));
    expq.push_back(e_clause(22'h0, 4'h0, 4'hF, 8'h00, 8'hFF, 7'h00));
    expq.push_back(e_exp(7'h7F, 12'hFFF));
    expq.push_back({2'd2, 64'd0});
    run("P2");

    // P3: unknown normal opcode halts (R9)
    clear_mem();
    mem[0] = w_norm(NOP, 1'b0, 2'd0, 13'd0, 7'd0, 12'd0, 4'd0);
    mem[1] = w_norm(7'h10, 1'b1, 2'd0, 13'd0, 7'd0, 12'd0, 4'd0);
    mem[2] = w_norm(EXP, 1'b1, 2'd1, 13'd60, 7'd1, 12'd1, 4'd0);
    expq.push_back({2'd3, 64'd0});
    run("P3");
    chk(err && !done, "R9 halted not done", {done, err}, 2'b01);

    // P4: export of wrong type (R9)
    clear_mem();
    mem[0] = w_norm(EXP, 1'b0, 2'd2, 13'd60, 7'd4, 12'd5, 4'd0);
    expq.push_back({2'd3, 64'd0});
    run("P4");

    // P5: ALU kind 14 (R3 R9)
    clear_mem();
    mem[0] = w_alu(22'd1, 4'd1, 4'd1, 8'd1, 8'd1, 7'd1, 4'd14);
    expq.push_back({2'd3, 64'd0});
    run("P5");

    // P6: nonzero burst (R9)
    clear_mem();
    mem[0] = w_norm(EXP, 1'b1, 2'd1, 13'd60, 7'd4, 12'd5, 4'd1);
    expq.push_back({2'd3, 64'd0});
    run("P6");

    // P7: wrong array base (R9)
    clear_mem();
    mem[0] = w_norm(EXPL, 1'b1, 2'd1, 13'd61, 7'd4, 12'd5, 4'd0);
    expq.push_back({2'd3, 64'd0});
    run("P7");

    // P8: restart after a halt (R10)
    clear_mem();
    mem[0] = w_norm(EXP, 1'b0, 2'd1, 13'd60, 7'd33, 12'o7012, 4'd0);
    mem[1] = w_norm(NOP, 1'b1, 2'd0, 13'd0, 7'd0, 12'd0, 4'd0);
    expq.push_back(e_exp(7'd33, 12'o7012));
    expq.push_back({2'd2, 64'd0});
    run("P8 R10");
    chk(done && !err, "R10 restart completes", {done, err}, 2'b10);

    finish_run();
  end
endmodule